// File: doc/BRIEF.md
# Scan chunk decimator

This block sits on a sample stream between a converter front end and its consumer. The front end converts at one fixed rate and produces back-to-back scans of N channels. The consumer wants a slower scan rate. The block cuts the stream into chunks of N×(1+D) samples, passes on the first scan of every chunk and discards the D scans that follow. D is the scan period divided by (N × convert period), minus one, so the scan period has to be a whole multiple of N conversions. The converter clock is never gated.

Both sides use a valid/ready handshake. The path is combinational: no sample is stored inside the block. A discarded sample is consumed at once, whatever the consumer is doing. The position within the chunk is counted only on accepted samples, so it carries across idle gaps and stalls of any length.

A start pulse captures the scan length, the delay and a stop count, and clears all progress. A scans counter advances each time the last channel of a kept scan is handed over. When the counter reaches a non-zero stop count, a sticky done flag is raised. A stop count of zero never raises it.

Top module: `scan_decim`

## Requirements
- R1: Of each chunk of N×(1+D) accepted samples, those at positions 0 to N−1 are presented on the output (out_valid_o high) and all later positions are not.
- R2: With a captured delay of D=0, every accepted sample is presented on the output.
- R3: A sample at a discarded position is accepted with in_ready_o high and out_valid_o low, independent of out_ready_i.
- R4: At a kept position, in_ready_o equals out_ready_i. The output carries the input data unchanged, and kept samples leave in arrival order with none lost or duplicated.
- R5: Chunk position changes only on an accepted sample. Idle cycles and stalled cycles leave it unchanged, and out_valid_o is low while in_valid_i is low.
- R6: After the last position of a chunk, the next accepted sample is position 0 of a new chunk.
- R7: A start_i pulse clears the chunk position, the scans counter and done_o. It captures scan_last_i (N−1, so N = scan_last_i+1), scan_delay_i (D) and stop_count_i. These three inputs have no effect at any other time.
- R8: The scans counter increments when the sample at channel N−1 of a kept scan is transferred. done_o rises one cycle after the transfer that makes the counter equal a non-zero stop count, and stays high until the next start_i.
- R9: With a captured stop count of 0, done_o stays low.
- R10: After reset the block behaves as if started with N=1, D=0 and stop count 0: every sample passes and done_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse: capture configuration, clear progress |
| scan_last_i | input | N_W | Scan length minus one (N−1) |
| scan_delay_i | input | D_W | Discarded scans per chunk (D) |
| stop_count_i | input | S_W | Kept scans until done, 0 means run forever |
| in_valid_i | input | 1 | Input sample valid |
| in_data_i | input | DATA_W | Input sample |
| in_ready_o | output | 1 | Input sample accepted |
| out_valid_o | output | 1 | Output sample valid |
| out_data_o | output | DATA_W | Output sample |
| out_ready_i | input | 1 | Consumer ready |
| done_o | output | 1 | Stop count of kept scans reached |

## Verification
If the channel or phase position goes wrong, the keep/drop pattern shifts. The shift shows on out_valid_o and in_ready_o at the first sample after the error. It also shows on the data that reaches the scoreboard, so it is seen within one chunk. A scans counter that is off moves the rise of done_o by whole scans, and that shows at the first scan boundary near the stop count. Backpressure is applied only on kept samples while discarded ones keep flowing. This separates a block that stalls on drops from one that does not.

// File: rtl/scan_decim_pkg.sv
package scan_decim_pkg;
  localparam int DEF_DATA_W = 16;
  localparam int DEF_N_W    = 4;
  localparam int DEF_D_W    = 8;
  localparam int DEF_S_W    = 16;

  typedef enum logic {
    ACT_KEEP = 1'b0,
    ACT_SKIP = 1'b1
  } act_e;
endpackage

// File: rtl/scan_decim_cfg.sv
module scan_decim_cfg #(
  parameter int N_W = 4,
  parameter int D_W = 8,
  parameter int S_W = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [N_W-1:0] scan_last_i,
  input  logic [D_W-1:0] scan_delay_i,
  input  logic [S_W-1:0] stop_count_i,
  output logic [N_W-1:0] last_o,
  output logic [D_W-1:0] dly_o,
  output logic [S_W-1:0] stop_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_o <= '0;
      dly_o  <= '0;
      stop_o <= '0;
    end else if (start_i) begin
      last_o <= scan_last_i;
      dly_o  <= scan_delay_i;
      stop_o <= stop_count_i;
    end
  end
endmodule

// File: rtl/scan_decim_pos.sv
module scan_decim_pos
  import scan_decim_pkg::*;
#(
  parameter int N_W = 4,
  parameter int D_W = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           adv_i,
  input  logic [N_W-1:0] last_i,
  input  logic [D_W-1:0] dly_i,
  output logic [N_W-1:0] chan_o,
  output logic [D_W-1:0] phase_o,
  output act_e           act_o,
  output logic           scan_end_o
);
  logic [N_W-1:0] chan_q;
  logic [D_W-1:0] phase_q;
  logic           chan_wrap;

  assign chan_wrap  = (chan_q == last_i);
  assign act_o      = (phase_q == '0) ? ACT_KEEP : ACT_SKIP;
  assign scan_end_o = chan_wrap && (act_o == ACT_KEEP);
  assign chan_o     = chan_q;
  assign phase_o    = phase_q;

  // chunk = (last+1) channels x (dly+1) phases; only phase 0 is kept
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chan_q  <= '0;
      phase_q <= '0;
    end else if (start_i) begin
      chan_q  <= '0;
      phase_q <= '0;
    end else if (adv_i) begin
      if (chan_wrap) begin
        chan_q  <= '0;
        phase_q <= (phase_q == dly_i) ? '0 : phase_q + 1'b1;
      end else begin
        chan_q  <= chan_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/scan_decim_cnt.sv
module scan_decim_cnt #(
  parameter int S_W = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           tick_i,
  input  logic [S_W-1:0] stop_i,
  output logic           done_o
);
  logic [S_W-1:0] scans_q;
  logic [S_W-1:0] scans_nxt;

  assign scans_nxt = scans_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scans_q <= '0;
      done_o  <= 1'b0;
    end else if (start_i) begin
      scans_q <= '0;
      done_o  <= 1'b0;
    end else if (tick_i) begin
      scans_q <= scans_nxt;
      if ((stop_i != '0) && (scans_nxt == stop_i)) done_o <= 1'b1;
    end
  end
endmodule

// File: rtl/scan_decim.sv
module scan_decim
  import scan_decim_pkg::*;
#(
  parameter int DATA_W = DEF_DATA_W,
  parameter int N_W    = DEF_N_W,
  parameter int D_W    = DEF_D_W,
  parameter int S_W    = DEF_S_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [N_W-1:0]    scan_last_i,
  input  logic [D_W-1:0]    scan_delay_i,
  input  logic [S_W-1:0]    stop_count_i,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              in_ready_o,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o,
  input  logic              out_ready_i,
  output logic              done_o
);
  logic [N_W-1:0] last_w;
  logic [D_W-1:0] dly_w;
  logic [S_W-1:0] stop_w;
  logic [N_W-1:0] chan_w;
  logic [D_W-1:0] phase_w;
  act_e           act_w;
  logic           scan_end_w;
  logic           xfer_w;

  scan_decim_cfg #(.N_W(N_W), .D_W(D_W), .S_W(S_W)) u_cfg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .scan_last_i  (scan_last_i),
    .scan_delay_i (scan_delay_i),
    .stop_count_i (stop_count_i),
    .last_o       (last_w),
    .dly_o        (dly_w),
    .stop_o       (stop_w)
  );

  // dropped samples never wait on the consumer
  assign in_ready_o  = (act_w == ACT_KEEP) ? out_ready_i : 1'b1;
  assign out_valid_o = in_valid_i && (act_w == ACT_KEEP);
  assign out_data_o  = in_data_i;
  assign xfer_w      = in_valid_i && in_ready_o;

  scan_decim_pos #(.N_W(N_W), .D_W(D_W)) u_pos (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .adv_i      (xfer_w),
    .last_i     (last_w),
    .dly_i      (dly_w),
    .chan_o     (chan_w),
    .phase_o    (phase_w),
    .act_o      (act_w),
    .scan_end_o (scan_end_w)
  );

  scan_decim_cnt #(.S_W(S_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .tick_i  (xfer_w && scan_end_w),
    .stop_i  (stop_w),
    .done_o  (done_o)
  );
endmodule

// File: rtl/scan_decim_chk.sv
module scan_decim_chk #(
  parameter int N_W = 4,
  parameter int D_W = 8,
  parameter int S_W = 16
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           start_i,
  input logic           in_valid_i,
  input logic           in_ready_o,
  input logic           out_valid_o,
  input logic           done_o,
  input logic [N_W-1:0] chan_w,
  input logic [D_W-1:0] phase_w,
  input logic [N_W-1:0] last_w,
  input logic [D_W-1:0] dly_w,
  input logic [S_W-1:0] stop_w
);
  // R3
  drop_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_w != '0) |-> (in_ready_o && !out_valid_o));

  // R2
  no_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dly_w == '0) |-> (phase_w == '0));

  // R6
  pos_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chan_w <= last_w) && (phase_w <= dly_w));

  // R5
  pos_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(in_valid_i && in_ready_o) && !start_i) |=> ($stable(chan_w) && $stable(phase_w)));

  // R7
  start_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> ((chan_w == '0) && (phase_w == '0) && !done_o));

  // R8
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);

  // R9
  no_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_w == '0) |-> !done_o);
endmodule

bind scan_decim scan_decim_chk #(.N_W(N_W), .D_W(D_W), .S_W(S_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .done_o      (done_o),
  .chan_w      (chan_w),
  .phase_w     (phase_w),
  .last_w      (last_w),
  .dly_w       (dly_w),
  .stop_w      (stop_w)
);

// File: tb/scan_decim_tb_top.sv
module scan_decim_tb_top;
  localparam int DATA_W = 16;
  localparam int N_W    = 4;
  localparam int D_W    = 8;
  localparam int S_W    = 16;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              start_i = 1'b0;
  logic [N_W-1:0]    scan_last_i = '0;
  logic [D_W-1:0]    scan_delay_i = '0;
  logic [S_W-1:0]    stop_count_i = '0;
  logic              in_valid_i = 1'b0;
  logic [DATA_W-1:0] in_data_i = '0;
  logic              in_ready_o;
  logic              out_valid_o;
  logic [DATA_W-1:0] out_data_o;
  logic              out_ready_i = 1'b1;
  logic              done_o;

  always #2 clk = ~clk;

  scan_decim #(.DATA_W(DATA_W), .N_W(N_W), .D_W(D_W), .S_W(S_W)) dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .scan_last_i  (scan_last_i),
    .scan_delay_i (scan_delay_i),
    .stop_count_i (stop_count_i),
    .in_valid_i   (in_valid_i),
    .in_data_i    (in_data_i),
    .in_ready_o   (in_ready_o),
    .out_valid_o  (out_valid_o),
    .out_data_o   (out_data_o),
    .out_ready_i  (out_ready_i),
    .done_o       (done_o)
  );

  int n_chk = 0;
  int n_err = 0;
  logic [DATA_W-1:0] exp_q[$];
  int m_last = 0, m_dly = 0, m_stop = 0, m_ch = 0, m_ph = 0, m_sc = 0;
  bit m_done = 1'b0;
  bit bp = 1'b0;
  logic [7:0] lfsr = 8'h5a;
  logic [DATA_W-1:0] seq = 16'h1000;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit next_rdy();
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    return bp ? lfsr[0] : 1'b1;
  endfunction

  task automatic chk_done();
    if (m_stop == 0) chk(done_o == m_done, "R9 done stays low", done_o, m_done);
    else             chk(done_o == m_done, "R8 done flag", done_o, m_done);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid_i  = 1'b0;
      out_ready_i = next_rdy();
      #1;
      chk(!out_valid_o, "R5 no output while idle", out_valid_o, 0);
      chk_done();
    end
  endtask

  task automatic send(input logic [DATA_W-1:0] d);
    bit keep;
    keep = (m_ph == 0);
    @(negedge clk);
    in_valid_i = 1'b1;
    in_data_i  = d;
    if (keep) exp_q.push_back(d);
    forever begin
      out_ready_i = next_rdy();
      #1;
      chk_done();
      chk(out_valid_o == keep, (m_dly == 0) ? "R2 all pass" : "R1 keep pattern", out_valid_o, keep);
      if (keep) chk(in_ready_o == out_ready_i, "R4 ready follows consumer", in_ready_o, out_ready_i);
      else      chk(in_ready_o == 1'b1, "R3 drop accepted", in_ready_o, 1);
      if (in_ready_o) break;
      @(negedge clk);
    end
    if (keep && m_ch == m_last) begin
      m_sc++;
      if (m_stop != 0 && m_sc == m_stop) m_done = 1'b1;
    end
    if (m_ch == m_last) begin
      m_ch = 0;
      m_ph = (m_ph == m_dly) ? 0 : m_ph + 1;
    end else begin
      m_ch++;
    end
  endtask

  task automatic start(input int last, input int dly, input int stop);
    @(negedge clk);
    in_valid_i   = 1'b0;
    start_i      = 1'b1;
    scan_last_i  = N_W'(last);
    scan_delay_i = D_W'(dly);
    stop_count_i = S_W'(stop);
    @(negedge clk);
    start_i = 1'b0;
    m_last = last; m_dly = dly; m_stop = stop;
    m_ch = 0; m_ph = 0; m_sc = 0; m_done = 1'b0;
    #1;
    chk(!done_o, "R7 start clears done", done_o, 0);
  endtask

  task automatic run(input int n, input int gap_every);
    for (int i = 0; i < n; i++) begin
      send(seq);
      seq = seq + 16'h0013;
      if (gap_every != 0 && (i % gap_every) == gap_every - 1) idle(2);
    end
    idle(2);
  endtask

  // scoreboard monitor
  always begin
    @(negedge clk);
    #1;
    if (out_valid_o && out_ready_i) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4 unexpected output", int'(out_data_o), -1);
      end else begin
        logic [DATA_W-1:0] e;
        e = exp_q.pop_front();
        chk(out_data_o == e, "R4 output data", int'(out_data_o), int'(e));
      end
    end
  end

  initial begin
    #(4 * 150000);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #1;
    chk(!done_o, "R10 done low in reset", done_o, 0);
    #10;
    rst_ni = 1'b1;
    idle(1);
    chk(in_ready_o == 1'b1, "R10 ready after reset", in_ready_o, 1);
    // R10: defaults N=1 D=0, everything passes
    run(6, 0);

    // R1 R6 R5: N=3, D=2, gaps, no backpressure
    start(2, 2, 0);
    run(40, 7);

    // R3 R4 R8: N=4, D=1, backpressure, stop after 3 scans
    bp = 1'b1;
    start(3, 1, 3);
    run(30, 5);
    chk(done_o == 1'b1, "R8 done after stop count", done_o, 1);

    // R7: change config inputs without start; captured values stay
    scan_last_i  = 4'd0;
    scan_delay_i = 8'd0;
    stop_count_i = 16'd1;
    run(12, 0);
    chk(done_o == 1'b1, "R7 done kept without start", done_o, 1);

    // R2 R9: N=2, D=0, stop 0, backpressure
    start(1, 0, 0);
    run(50, 9);

    // R6 R8: N=1, D=3, stop 2
    bp = 1'b0;
    start(0, 3, 2);
    run(20, 0);

    // R8: N=16 (max), D=0, stop 1
    bp = 1'b1;
    start(15, 0, 1);
    run(20, 0);

    chk(exp_q.size() == 0, "R4 all kept samples delivered", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule